// File: doc/BRIEF.md
# Dual-Channel Status Byte Buffer

This block stores channel status data for a pair of audio subframe channels, A and B, in a small register file of 24 sixteen-bit words. Each word pairs the two channels: channel A occupies the high byte and channel B the low byte. A host reaches the storage one byte at a time through a simple control port. The port offers a start-address load, an access strobe with a read/write select, a write byte, a registered read byte, a mode bit and a channel-select bit. A second, independent read port lets the transmit side fetch any whole word combinationally.

Two access modes are available. In one-byte mode a single host byte stands for both channels. A write stores that byte into both halves of the addressed word. A read returns either the A byte or the B byte, chosen by the channel-select bit. In two-byte mode the host moves the A byte and then the B byte. A two-byte write commits the word only when the B byte arrives, so a write abandoned after the A byte leaves storage untouched. The word pointer advances by itself after each completed word and wraps at the end of the buffer, so a whole block can be moved as one burst.

Top module: `chstat_pair_buf`

## Requirements
- R1: After a synchronous reset every word reads 0, the read byte is 0, the pointer is at word 0 and the next two-byte transfer is an A byte.
- R2: The transmit port returns the word at `tx_addr` in the same cycle, with the channel A byte in bits 15:8 and the channel B byte in bits 7:0. A `tx_addr` of 24 or more returns 0.
- R3: In one-byte mode, a read access loads `hst_rdata` after the clock edge. When `chan_sel_b`=0 it loads the A byte of the addressed word, and when `chan_sel_b`=1 it loads the B byte. A write access leaves `hst_rdata` unchanged.
- R4: In one-byte mode, a write access stores `hst_wdata` into both the A byte and the B byte of the addressed word.
- R5: In two-byte mode, two consecutive read accesses return the A byte of the addressed word and then its B byte.
- R6: In two-byte mode, the first write access (A byte) is held aside. The second (B byte) commits {A, B} to the addressed word, and the word does not change before then.
- R7: The pointer advances by one after every one-byte-mode access, and after the B-byte access in two-byte mode. It does not move after an A-byte access or while no access is made.
- R8: The pointer wraps from word 23 to word 0.
- R9: `hst_addr_ld`=1 loads `hst_addr` as the new pointer and makes the next two-byte transfer an A byte. A load value of 24 or more loads 0. An access strobed in the same cycle as a load is ignored.
- R10: A two-byte write abandoned after its A byte, by a new address load, leaves the addressed word unchanged.
- R11: Any one-byte-mode access also resets the two-byte sequence, so the next two-byte transfer is an A byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr_ld | input | 1 | Load `hst_addr` as the start word address |
| hst_addr | input | 5 | Start word address |
| hst_acc | input | 1 | Host byte access strobe |
| hst_wr | input | 1 | 1 = write access, 0 = read access |
| hst_wdata | input | 8 | Host write byte |
| mode_pair | input | 1 | 1 = two-byte mode, 0 = one-byte mode |
| chan_sel_b | input | 1 | One-byte read source: 0 = channel A, 1 = channel B |
| hst_rdata | output | 8 | Registered host read byte |
| tx_addr | input | 5 | Transmit-side word address |
| tx_word | output | 16 | Transmit-side word, A byte high and B byte low |

## Verification
The assertions check several things on every cycle: a one-byte write always presents a mirrored word to storage, an A-byte write never commits, an address load always clears the phase, the pointer stays in range and holds while idle, and it wraps at word 23. The bench's ordered scenarios are needed for the rest. Those cover the byte order of two-byte reads, the value a completed two-byte write lands in storage, an abandoned A byte leaving its word untouched, and a mode switch mid-sequence resetting the phase, all observed through the read byte and the transmit port.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

    localparam int unsigned WORDS  = 24;
    localparam int unsigned AW     = $clog2(WORDS);
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [AW-1:0]     waddr_t;

    typedef struct packed {
        byte_t a;
        byte_t b;
    } cs_word_t;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_t;

    function automatic waddr_t addr_step(input waddr_t cur);
        if (cur == waddr_t'(WORDS - 1)) begin
            return '0;
        end
        return cur + waddr_t'(1);
    endfunction

    function automatic waddr_t addr_clamp(input waddr_t raw);
        if (raw >= waddr_t'(WORDS)) begin
            return '0;
        end
        return raw;
    endfunction

endpackage

// File: rtl/chstat_ptr.sv
module chstat_ptr
    import chstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  waddr_t ld_addr,
    input  logic   acc,
    input  logic   pair,
    output waddr_t ptr,
    output phase_t phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            phase <= PH_A;
        end else if (ld) begin
            ptr   <= addr_clamp(ld_addr);
            phase <= PH_A;
        end else if (acc) begin
            if (!pair) begin
                ptr   <= addr_step(ptr);
                phase <= PH_A;
            end else if (phase == PH_B) begin
                ptr   <= addr_step(ptr);
                phase <= PH_A;
            end else begin
                phase <= PH_B;
            end
        end
    end

endmodule

// File: rtl/chstat_regfile.sv
module chstat_regfile
    import chstat_pkg::*;
#(
    parameter int unsigned DEPTH = WORDS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  waddr_t   waddr,
    input  cs_word_t wdata,
    input  waddr_t   raddr_h,
    output cs_word_t rdata_h,
    input  waddr_t   raddr_t,
    output cs_word_t rdata_t
);

    cs_word_t mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && (waddr == waddr_t'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_h = '0;
        rdata_t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_h == waddr_t'(i)) rdata_h = mem[i];
            if (raddr_t == waddr_t'(i)) rdata_t = mem[i];
        end
    end

endmodule

// File: rtl/chstat_port.sv
module chstat_port
    import chstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld,
    input  logic     acc,
    input  logic     wr,
    input  logic     pair,
    input  logic     sel_b,
    input  byte_t    wbyte,
    input  phase_t   phase,
    input  cs_word_t cur_word,
    output logic     we,
    output cs_word_t wword,
    output byte_t    rbyte
);

    byte_t  a_hold;
    logic   live;

    assign live = acc && !ld;

    always_comb begin
        we    = 1'b0;
        wword = '0;
        if (live && wr) begin
            if (!pair) begin
                we    = 1'b1;
                wword = '{a: wbyte, b: wbyte};
            end else if (phase == PH_B) begin
                we    = 1'b1;
                wword = '{a: a_hold, b: wbyte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_hold <= '0;
            rbyte  <= '0;
        end else if (live) begin
            if (wr) begin
                if (pair && phase == PH_A) a_hold <= wbyte;
            end else if (!pair) begin
                rbyte <= sel_b ? cur_word.b : cur_word.a;
            end else begin
                rbyte <= (phase == PH_A) ? cur_word.a : cur_word.b;
            end
        end
    end

endmodule

// File: rtl/chstat_pair_buf.sv
module chstat_pair_buf
    import chstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hst_addr_ld,
    input  logic [4:0]  hst_addr,
    input  logic        hst_acc,
    input  logic        hst_wr,
    input  logic [7:0]  hst_wdata,
    input  logic        mode_pair,
    input  logic        chan_sel_b,
    output logic [7:0]  hst_rdata,
    input  logic [4:0]  tx_addr,
    output logic [15:0] tx_word
);

    waddr_t   ptr;
    phase_t   phase;
    logic     wr_en;
    cs_word_t wr_word;
    cs_word_t cur_word;
    cs_word_t tx_w;

    chstat_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld      (hst_addr_ld),
        .ld_addr (hst_addr),
        .acc     (hst_acc),
        .pair    (mode_pair),
        .ptr     (ptr),
        .phase   (phase)
    );

    chstat_port u_port (
        .clk      (clk),
        .rst      (rst),
        .ld       (hst_addr_ld),
        .acc      (hst_acc),
        .wr       (hst_wr),
        .pair     (mode_pair),
        .sel_b    (chan_sel_b),
        .wbyte    (hst_wdata),
        .phase    (phase),
        .cur_word (cur_word),
        .we       (wr_en),
        .wword    (wr_word),
        .rbyte    (hst_rdata)
    );

    chstat_regfile #(.DEPTH(WORDS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (ptr),
        .wdata   (wr_word),
        .raddr_h (ptr),
        .rdata_h (cur_word),
        .raddr_t (tx_addr),
        .rdata_t (tx_w)
    );

    assign tx_word = tx_w;

endmodule

// File: rtl/chstat_pair_buf_chk.sv
module chstat_pair_buf_chk
    import chstat_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ld,
    input logic     acc,
    input logic     wr,
    input logic     pair,
    input waddr_t   ptr,
    input phase_t   phase,
    input logic     we,
    input cs_word_t wword
);

    // R4
    mirror_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld && wr && !pair) |-> (we && wword.a == wword.b));

    // R6
    a_byte_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld && wr && pair && phase == PH_A) |-> !we);

    // R9
    load_clears_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> (phase == PH_A));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld && !pair && ptr == waddr_t'(WORDS - 1)) |=> (ptr == '0));

    // R7
    ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && !acc) |=> $stable(ptr));

    // R7
    a_byte_no_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld && pair && phase == PH_A) |=> ($stable(ptr) && phase == PH_B));

    // R11
    single_resets_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld && !pair) |=> (phase == PH_A));

    // R8
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr < waddr_t'(WORDS));

endmodule

bind chstat_pair_buf chstat_pair_buf_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .ld    (hst_addr_ld),
    .acc   (hst_acc),
    .wr    (hst_wr),
    .pair  (mode_pair),
    .ptr   (ptr),
    .phase (phase),
    .we    (wr_en),
    .wword (wr_word)
);

// File: tb/chstat_pair_buf_bench.sv
module chstat_pair_buf_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        hst_addr_ld;
    logic [4:0]  hst_addr;
    logic        hst_acc;
    logic        hst_wr;
    logic [7:0]  hst_wdata;
    logic        mode_pair;
    logic        chan_sel_b;
    logic [7:0]  hst_rdata;
    logic [4:0]  tx_addr;
    logic [15:0] tx_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    chstat_pair_buf u_chstat_pair_buf (
        .clk         (clk),
        .rst         (rst),
        .hst_addr_ld (hst_addr_ld),
        .hst_addr    (hst_addr),
        .hst_acc     (hst_acc),
        .hst_wr      (hst_wr),
        .hst_wdata   (hst_wdata),
        .mode_pair   (mode_pair),
        .chan_sel_b  (chan_sel_b),
        .hst_rdata   (hst_rdata),
        .tx_addr     (tx_addr),
        .tx_word     (tx_word)
    );

    typedef struct packed {
        logic        ld;
        logic [4:0]  a;
        logic        acc;
        logic        wr;
        logic        pair;
        logic        selb;
        logic [7:0]  wd;
        logic [4:0]  txa;
        logic [15:0] etx;
        logic        crd;
        logic [7:0]  erd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd3,  16'h0000, 1'b0, 8'h00, 4'd9},  // R9 load 3
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 5'd3,  16'h5A5A, 1'b0, 8'h00, 4'd4},  // R4 mirror
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 5'd4,  16'h1111, 1'b0, 8'h00, 4'd7},  // R7 advance
        '{1'b1, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd4,  16'h1111, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd3,  16'h5A5A, 1'b1, 8'h5A, 4'd3},  // R3 sel A
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 5'd4,  16'h1111, 1'b1, 8'h11, 4'd3},  // R3 sel B
        '{1'b1, 5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'h0000, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'hC3, 5'd10, 16'h0000, 1'b0, 8'h00, 4'd6},  // R6 A held
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h7E, 5'd10, 16'hC37E, 1'b0, 8'h00, 4'd6},  // R6 commit
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h22, 5'd11, 16'h0000, 1'b0, 8'h00, 4'd7},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h44, 5'd11, 16'h2244, 1'b0, 8'h00, 4'd2},  // R2 layout
        '{1'b1, 5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'hC37E, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 5'd10, 16'hC37E, 1'b1, 8'hC3, 4'd5},  // R5 A first
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 5'd10, 16'hC37E, 1'b1, 8'h7E, 4'd5},  // R5 B second
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 5'd11, 16'h2244, 1'b1, 8'h22, 4'd7},  // R7 after B
        '{1'b1, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd12, 16'h0000, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h99, 5'd12, 16'h0000, 1'b0, 8'h00, 4'd10}, // R10
        '{1'b1, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd12, 16'h0000, 1'b0, 8'h00, 4'd10},
        '{1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd12, 16'h0000, 1'b0, 8'h00, 4'd10},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 5'd12, 16'h0000, 1'b0, 8'h00, 4'd9},  // R9 phase A
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h02, 5'd12, 16'h0102, 1'b0, 8'h00, 4'd9},
        '{1'b1, 5'd23, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd23, 16'h0000, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'hEE, 5'd23, 16'hEEEE, 1'b0, 8'h00, 4'd4},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 5'd0,  16'h3333, 1'b0, 8'h00, 4'd8},  // R8 wrap
        '{1'b1, 5'd23, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd23, 16'hEEEE, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'hAB, 5'd23, 16'hEEEE, 1'b0, 8'h00, 4'd6},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'hCD, 5'd23, 16'hABCD, 1'b0, 8'h00, 4'd6},
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 5'd0,  16'h3333, 1'b1, 8'h33, 4'd8},  // R8 pair wrap
        '{1'b1, 5'd5,  1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 5'd5,  16'h0000, 1'b0, 8'h00, 4'd9},  // R9 ld wins
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd5,  16'h0000, 1'b1, 8'h00, 4'd9},
        '{1'b1, 5'd30, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd0,  16'h3333, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 5'd0,  16'h3333, 1'b1, 8'h33, 4'd9},  // R9 clamp
        '{1'b1, 5'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd14, 16'h0000, 1'b0, 8'h00, 4'd9},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 5'd14, 16'h0000, 1'b0, 8'h00, 4'd11}, // R11
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'h66, 5'd14, 16'h6666, 1'b0, 8'h00, 4'd11},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 5'd15, 16'h0000, 1'b0, 8'h00, 4'd11},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 8'h20, 5'd15, 16'h1020, 1'b0, 8'h00, 4'd11},
        '{1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd24, 16'h0000, 1'b0, 8'h00, 4'd2}   // R2 range
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hst_addr_ld = 1'b0;
        hst_addr    = '0;
        hst_acc     = 1'b0;
        hst_wr      = 1'b0;
        hst_wdata   = '0;
        mode_pair   = 1'b0;
        chan_sel_b  = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        hst_addr_ld = v.ld;
        hst_addr    = v.a;
        hst_acc     = v.acc;
        hst_wr      = v.wr;
        hst_wdata   = v.wd;
        mode_pair   = v.pair;
        chan_sel_b  = v.selb;
        tx_addr     = v.txa;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        tx_addr = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata after reset", {8'h00, hst_rdata}, 16'h0000);
        for (int w = 0; w < 24; w += 7) begin
            tx_addr = 5'(w);
            #1;
            check("R1 word after reset", tx_word, 16'h0000);
        end
        // R1 pointer at 0 and phase A: two-byte write lands at word 0
        apply('{1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 5'd0, 16'h0, 1'b0, 8'h0, 4'd1});
        apply('{1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h42, 5'd0, 16'h0, 1'b0, 8'h0, 4'd1});
        check("R1 pointer/phase from reset", tx_word, 16'h8142);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tx_addr = 5'd0;
        #1;
        check("R1 word cleared by reset", tx_word, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R%0d vec %0d tx_word", VECS[i].req, i), tx_word, VECS[i].etx);
            if (VECS[i].crd) begin
                check($sformatf("R%0d vec %0d hst_rdata", VECS[i].req, i),
                      {8'h00, hst_rdata}, {8'h00, VECS[i].erd});
            end
        end

        // R3 write access leaves the read byte untouched
        apply('{1'b1, 5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'h0, 1'b0, 8'h0, 4'd3});
        apply('{1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 5'd10, 16'h0, 1'b0, 8'h0, 4'd3});
        apply('{1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5C, 5'd11, 16'h0, 1'b0, 8'h0, 4'd3});
        check("R3 rdata held over write", {8'h00, hst_rdata}, 16'h00C3);
        check("R4 mirror at word 11", tx_word, 16'h5C5C);

        // R10 abandoned A byte at word 11 followed by reset-free reload
        apply('{1'b1, 5'd11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd11, 16'h0, 1'b0, 8'h0, 4'd10});
        apply('{1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hDD, 5'd11, 16'h0, 1'b0, 8'h0, 4'd10});
        apply('{1'b1, 5'd11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd11, 16'h0, 1'b0, 8'h0, 4'd10});
        apply('{1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 5'd11, 16'h0, 1'b0, 8'h0, 4'd10});
        check("R10 word after abandon", tx_word, 16'h5C5C);
        check("R10 A byte read after reload", {8'h00, hst_rdata}, 16'h005C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule